// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a 16-bit down-counter that produces a periodic interrupt for a processor on a simple register bus. Software picks a power-of-two prescale exponent. The counter then steps down once every 2 × 2^exponent system clocks. When it runs out, it either reloads from a programmed modulus or wraps to 0xFFFF, and it raises an interrupt flag. The interrupt output is a level. It stays high while that flag and its enable are both set. Software clears the flag by writing a one to it.

Three registers sit behind a 3-bit byte offset. Offset 0x0 holds control and status. Offset 0x2 holds the modulus. Offset 0x4 returns the live count. Reads are combinational and only return data while the access strobe is high. Writes take effect on the clock edge on which the strobe and write enable are both high.

Top module: `intv_timer`

## Requirements
- R1: After synchronous reset the control register reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF, and irq is low.
- R2: Control bit layout: bit 0 enable, bit 1 reload mode, bit 2 flag, bit 3 interrupt enable, bit 4 overwrite, bit 5 debug-hold, bit 6 doze-hold, bits 11:8 prescale exponent. Other bits read as zero. The offsets are 0x0 for control, 0x2 for modulus and 0x4 for count.
- R3: While enabled, the count falls by one every 2·2^P clocks, where P is the exponent. The first step comes 2·2^P clocks after the edge that started counting.
- R4: A step taken at count 0 loads the modulus when reload mode is 1 and 0xFFFF when it is 0. On the same edge it sets the flag.
- R5: irq is high exactly while the flag and the interrupt enable are both 1.
- R6: Writing 1 to control bit 2 clears the flag and writing 0 leaves it as it is. An expiry on the same edge as a clearing write leaves the flag set.
- R7: A control write whose only differences from the stored value are the interrupt enable and the flag-clear bit keeps the count and the prescaler phase as they were.
- R8: Any other control write restarts the prescaler. If the new enable is 1, it loads the count with the modulus (new reload mode 1) or 0xFFFF (new reload mode 0). If the new enable is 0, the count freezes.
- R9: A modulus write stores the value. With overwrite set, it also loads that value into the count and restarts the prescaler. With overwrite clear, the count is untouched until the next reload.
- R10: The debug-hold and doze-hold bits are stored and read back and have no effect on the count rate.
- R11: Any offset other than 0x0, 0x2 and 0x4 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not selected |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the exact step period at several exponents. A design that counted on every clock, or on the undivided prescale factor, would raise irq early. It also checks the expiry edge. A design off by one there would show a stale count, or a flag one cycle late, beside a model that is checked every clock. The bench tells an enable-only write apart from a real reconfiguration. A design that restarted on every control write would leave the count at the modulus when it should have carried on. It also checks that a modulus write without overwrite leaves the live count unchanged, that invalid offsets read zero and are ignored, and that a flag clear colliding with an expiry keeps the flag. That last collision is reached through long randomized runs.

// File: rtl/intv_pkg.sv
// Package: shared widths and the control register type for the interval timer.
// Assumes a 16-bit data path and a 3-bit byte offset.
package intv_pkg;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_MOD  = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'h4;

    // Control fields, most significant first.
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             flag;
        logic             rld;
        logic             en;
    } ctrl_t;

    // Place the control fields at their bus bit positions.
    function automatic logic [CNT_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [CNT_W-1:0] w;
        w = '0;
        w[0]    = c.en;
        w[1]    = c.rld;
        w[2]    = c.flag;
        w[3]    = c.ie;
        w[4]    = c.ovw;
        w[5]    = c.dbg;
        w[6]    = c.doze;
        w[11:8] = c.pre;
        return w;
    endfunction
endpackage

// File: rtl/intv_prescaler.sv
// Prescaler: emits a one-cycle tick every 2*2^pre clocks while enabled.
// Assumes clr restarts the phase; a tick is never emitted on a clr cycle.
module intv_prescaler #(
    parameter int PRE_W = intv_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W) + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;

    // Terminal value of the divider for the selected exponent.
    always_comb div_lim = (DIV_W'(2) << pre) - DIV_W'(1);

    assign tick = en && !clr && (div_q == div_lim);

    // Divider phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en || tick) div_q <= '0;
        else                              div_q <= div_q + DIV_W'(1);
    end

    // R3: the shortest period is two clocks, so ticks never come back to back.
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/intv_downcounter.sv
// Down-counter: steps on tick, reloads or wraps at zero, accepts direct loads.
// Assumes load and tick are never both high (load restarts the prescaler).
module intv_downcounter #(
    parameter int CNT_W = intv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rld,
    input  logic [CNT_W-1:0] mod_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = tick && (count == '0);

    // Live count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '1;
        else if (load)   count <= load_val;
        else if (expire) count <= rld ? mod_val : '1;
        else if (tick)   count <= count - CNT_W'(1);
    end

    // R8: with neither a load nor a tick the count holds.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count));
    // R3: an ordinary step lowers the count by one.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != '0) |=> count == $past(count) - CNT_W'(1));
endmodule

// File: rtl/intv_ctrl_regs.sv
// Control and modulus registers: field storage, flag set/clear, restart and
// load decisions. Assumes a single bus operation per cycle.
module intv_ctrl_regs
    import intv_pkg::*;
#(
    parameter int CNT_W = intv_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_mod,
    input  logic [CNT_W-1:0] wdata,
    input  logic             expire,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] mod_q,
    output logic             restart,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    ctrl_t wr_f;

    // Decode the write data into control fields.
    always_comb begin
        wr_f      = '0;
        wr_f.en   = wdata[0];
        wr_f.rld  = wdata[1];
        wr_f.flag = wdata[2];
        wr_f.ie   = wdata[3];
        wr_f.ovw  = wdata[4];
        wr_f.dbg  = wdata[5];
        wr_f.doze = wdata[6];
        wr_f.pre  = wdata[11:8];
    end

    // A control write restarts counting unless only ie / flag-clear differ.
    always_comb begin
        restart = wr_ctrl && ({wr_f.pre, wr_f.doze, wr_f.dbg, wr_f.ovw, wr_f.rld, wr_f.en}
                           != {ctrl.pre, ctrl.doze, ctrl.dbg, ctrl.ovw, ctrl.rld, ctrl.en});
    end

    // Select when and what the counter loads.
    always_comb begin
        load     = (restart && wr_f.en) || (wr_mod && ctrl.ovw);
        load_val = wr_mod ? wdata : (wr_f.rld ? mod_q : '1);
    end

    // Control fields and flag: expiry wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en   <= wr_f.en;
                ctrl.rld  <= wr_f.rld;
                ctrl.ie   <= wr_f.ie;
                ctrl.ovw  <= wr_f.ovw;
                ctrl.dbg  <= wr_f.dbg;
                ctrl.doze <= wr_f.doze;
                ctrl.pre  <= wr_f.pre;
            end
            if (expire)                     ctrl.flag <= 1'b1;
            else if (wr_ctrl && wr_f.flag)  ctrl.flag <= 1'b0;
        end
    end

    // Modulus storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '1;
        else if (wr_mod) mod_q <= wdata;
    end

    // R6: a clearing write with no expiry leaves the flag low.
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[2] && !expire) |=> !ctrl.flag);
    // R4: expiry always sets the flag.
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctrl.flag);
endmodule

// File: rtl/intv_timer.sv
// Top: prescaled periodic interval timer on a simple register bus.
// Assumes combinational reads and writes on the strobed clock edge.
module intv_timer
    import intv_pkg::*;
#(
    parameter int CNT_W  = intv_pkg::CNT_W,
    parameter int PRE_W  = intv_pkg::PRE_W,
    parameter int ADDR_W = intv_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;
    logic             wr_ctrl, wr_mod, restart, load, tick, expire;

    assign wr_ctrl = bus_sel && bus_we && (bus_addr == OFS_CTRL);
    assign wr_mod  = bus_sel && bus_we && (bus_addr == OFS_MOD);

    intv_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mod(wr_mod),
        .wdata(bus_wdata), .expire(expire), .ctrl(ctrl), .mod_q(mod_q),
        .restart(restart), .load(load), .load_val(load_val)
    );

    intv_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .clr(restart || load),
        .pre(ctrl.pre), .tick(tick)
    );

    intv_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rld(ctrl.rld),
        .mod_val(mod_q), .load(load), .load_val(load_val),
        .count(count), .expire(expire)
    );

    // Level interrupt from flag and enable.
    assign irq = ctrl.flag && ctrl.ie;

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = ctrl_to_word(ctrl);
                OFS_MOD:  bus_rdata = mod_q;
                OFS_CNT:  bus_rdata = count;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R9: an overwrite modulus write lands in the live count.
    a_r9_ovw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && ctrl.ovw) |=> count == $past(bus_wdata));
    // R5: with interrupts disabled irq stays low.
    a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.ie |-> !irq);
endmodule

// File: tb/intv_timer_test.sv
// Bench: behavioural reference model checked on every clock, plus directed cases.
module intv_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state.
    int m_en, m_rld, m_flag, m_ie, m_ovw, m_dbg, m_doze, m_pre;
    int m_mod, m_cnt, m_div;

    intv_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic int m_read(input int a);
        case (a)
            0: return m_en | (m_rld << 1) | (m_flag << 2) | (m_ie << 3) | (m_ovw << 4)
                      | (m_dbg << 5) | (m_doze << 6) | (m_pre << 8);
            2: return m_mod;
            4: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // Model update at each edge from the inputs held since the last edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_rld = 0; m_flag = 0; m_ie = 0; m_ovw = 0; m_dbg = 0;
            m_doze = 0; m_pre = 0; m_mod = 16'hFFFF; m_cnt = 16'hFFFF; m_div = 0;
        end else begin
            int w, per, nw_en, nw_rld;
            bit wc, wm, chg, ld, tk, ex;
            w = int'(bus_wdata);
            wc = bus_sel && bus_we && bus_addr == 3'h0;
            wm = bus_sel && bus_we && bus_addr == 3'h2;
            nw_en = w & 1; nw_rld = (w >> 1) & 1;
            chg = wc && (nw_en != m_en || nw_rld != m_rld || ((w >> 4) & 1) != m_ovw ||
                         ((w >> 5) & 1) != m_dbg || ((w >> 6) & 1) != m_doze ||
                         ((w >> 8) & 15) != m_pre);
            ld = (chg && nw_en == 1) || (wm && m_ovw == 1);
            per = 2 << m_pre;
            tk = m_en == 1 && !chg && !ld && m_div == per - 1;
            ex = tk && m_cnt == 0;
            if (ld) m_cnt = wm ? w : (nw_rld == 1 ? m_mod : 16'hFFFF);
            else if (ex) m_cnt = m_rld == 1 ? m_mod : 16'hFFFF;
            else if (tk) m_cnt = m_cnt - 1;
            if (chg || ld || m_en == 0 || tk) m_div = 0; else m_div = m_div + 1;
            if (ex) m_flag = 1; else if (wc && ((w >> 2) & 1) == 1) m_flag = 0;
            if (wc) begin
                m_en = nw_en; m_rld = nw_rld; m_ie = (w >> 3) & 1; m_ovw = (w >> 4) & 1;
                m_dbg = (w >> 5) & 1; m_doze = (w >> 6) & 1; m_pre = (w >> 8) & 15;
            end
            if (wm) m_mod = w;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R5: irq compared against the model every clock.
    always @(posedge clk) begin
        #15;
        if (rst_n && !done) chk("R5", int'(irq), m_flag & m_ie);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #5;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input string tag, output int v);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        v = int'(bus_rdata);
        chk(tag, v, m_read(int'(a)));
        bus_sel = 0;
    endtask

    task automatic rd_exp(input logic [2:0] a, input string tag, input int exp);
        int v;
        bus_rd(a, tag, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c1, c2;
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        rd_exp(3'h0, "R1", 0);
        rd_exp(3'h2, "R1", 16'hFFFF);
        rd_exp(3'h4, "R1", 16'hFFFF);
        chk("R1", int'(irq), 0);
        // R3/R4: modulus 5, prescale 1 -> expiry 12 clocks after enabling
        bus_wr(3'h2, 16'd5);
        rd_exp(3'h2, "R9", 5);
        bus_wr(3'h0, 16'h000B);
        step(11);
        chk("R3", int'(irq), 0);
        rd_exp(3'h4, "R3", 0);
        step(1);
        chk("R4", int'(irq), 1);
        rd_exp(3'h4, "R4", 5);
        // R6 clear the flag by writing one, R7 same other fields
        bus_wr(3'h0, 16'h000F);
        chk("R6", int'(irq), 0);
        rd_exp(3'h0, "R2", 16'h000B);
        step(3);
        bus_wr(3'h0, 16'h0003);
        rd_exp(3'h4, "R7", 3);
        // R8 disabling freezes the count
        bus_wr(3'h0, 16'h0000);
        bus_rd(3'h4, "R8", c1);
        step(10);
        bus_rd(3'h4, "R8", c2);
        chk("R8", c2, c1);
        // R3 prescale exponent 2 with modulus 1: expiry 16 clocks after enabling
        bus_wr(3'h2, 16'd1);
        bus_wr(3'h0, 16'h020B);
        step(15);
        chk("R3", int'(irq), 0);
        step(1);
        chk("R3", int'(irq), 1);
        // R10 debug/doze set: identical period
        bus_wr(3'h0, 16'h006C);
        bus_wr(3'h0, 16'h026B);
        rd_exp(3'h0, "R10", 16'h026B);
        step(15);
        chk("R10", int'(irq), 0);
        step(1);
        chk("R10", int'(irq), 1);
        // R4 free-running start loads 0xFFFF
        bus_wr(3'h0, 16'h000D);
        rd_exp(3'h4, "R4", 16'hFFFF);
        // R9 overwrite loads the live count
        bus_wr(3'h0, 16'h0F13);
        bus_wr(3'h2, 16'h0100);
        rd_exp(3'h4, "R9", 16'h0100);
        // R9 without overwrite the count stays
        bus_wr(3'h0, 16'h0F03);
        bus_rd(3'h4, "R9", c1);
        bus_wr(3'h2, 16'd7);
        rd_exp(3'h4, "R9", c1);
        rd_exp(3'h2, "R9", 7);
        // R11 unmapped offset
        bus_wr(3'h6, 16'hFFFF);
        rd_exp(3'h6, "R11", 0);
        rd_exp(3'h0, "R11", 16'h0F03);
        rd_exp(3'h2, "R11", 7);
        // Randomised traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int op, v;
            op = int'($urandom_range(0, 9));
            if (op == 0)
                bus_wr(3'h0, 16'(($urandom_range(0, 2) << 8) | $urandom_range(0, 127)));
            else if (op == 1)
                bus_wr(3'h0, 16'(m_read(0) ^ 8 | ($urandom_range(0, 1) << 2)));
            else if (op == 2)
                bus_wr(3'h2, 16'($urandom_range(0, 12)));
            else if (op == 3)
                bus_wr(3'($urandom_range(5, 7)), 16'($urandom));
            else if (op == 4)
                bus_rd(3'h0, "R2", v);
            else if (op == 5)
                bus_rd(3'h4, "R4", v);
            else
                step(int'($urandom_range(1, 6)));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule